// File: doc/BRIEF.md
# Dual-Port Word Memory with Busy-Gated Writes

This block is a synchronous two-port memory of 4096 words. The word width is a parameter and is either 8 or 9 bits. Each port has its own controls: an active-low select, an active-low read/write line (low means write), an active-low output enable, an address, a write-data bus, and a registered read-data bus with a valid flag. The ports work independently of each other on a shared clock. A read returns its word one cycle after it is issued.

Each port has a busy flag. While a port's busy flag is high, that port can neither write nor read. A mode input sets where the busy flags come from. In master mode they come from an arbiter next to the block, and the block repeats them on its busy outputs so that slave copies can follow. In slave mode they come from external pins driven by a master copy, and the busy outputs stay low. Several copies can be placed side by side to make a wider word. One copy runs as master and the others run as slaves on the same busy lines, so no copy commits a write that the arbiter has refused.

Top module: `dual_port_busy_ram`

## Requirements
- R1: The memory holds 4096 words of DATA_W bits (8 or 9). Every address from 0 to 4095 can be written and read back from either port.
- R2: While a port's select is high, that port does not write. Its valid flag is low on the next cycle, and its read data keeps its last value. After reset, both valid flags are low and both data outputs are zero.
- R3: A read happens when select is low, read/write is high, output enable is low and the port is not busy. On the next clock cycle the port's valid flag is high and its data output carries the stored word.
- R4: A write happens when select is low, read/write is low and the port is not busy. The word is stored at that clock edge. The output enable has no effect on a write, and the valid flag is low on the next cycle.
- R5: If output enable is high while read/write is high, nothing is read. The valid flag is low on the next cycle and the data output holds its value.
- R6: With the mode input high (master), each port's busy flag is taken from its arbiter input, and the busy output repeats that value. With the mode input low (slave), the busy flag is taken from the external busy input, and the busy output is low.
- R7: A write issued while its port is busy is discarded and is not retried. The addressed word keeps its old value.
- R8: A read issued while its port is busy produces no valid data, and the data output holds. When the same read is issued after the busy flag has cleared, it returns the newest data, including a word the other port wrote in the meantime.
- R9: If one port writes a location in the same cycle that the other port reads it, the read returns the old word. A read of that location on the next cycle returns the new word.
- R10: If both ports write the same address in the same cycle, the word from port A is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| master_sel | input | 1 | 1 = master (busy flags from the arbiter inputs), 0 = slave (busy flags from the external inputs) |
| arb_busy_a | input | 1 | Busy flag for port A from the arbiter (master mode) |
| arb_busy_b | input | 1 | Busy flag for port B from the arbiter (master mode) |
| ext_busy_a | input | 1 | Busy flag for port A from an external master (slave mode) |
| ext_busy_b | input | 1 | Busy flag for port B from an external master (slave mode) |
| busy_out_a | output | 1 | Port A busy flag repeated for slave copies; low in slave mode |
| busy_out_b | output | 1 | Port B busy flag repeated for slave copies; low in slave mode |
| a_sel_n | input | 1 | Port A select, active low |
| a_wr_n | input | 1 | Port A read/write: 0 = write, 1 = read |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data (registered) |
| a_rvalid | output | 1 | Port A read data valid |
| b_sel_n | input | 1 | Port B select, active low |
| b_wr_n | input | 1 | Port B read/write: 0 = write, 1 = read |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data (registered) |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
The properties assume that the control inputs and busy inputs are settled at each rising clock edge. They also assume that whoever drives the busy lines is free to make them any pattern, including both ports busy together. No assumption is made about arbiter fairness. The stimulus changes every input only on the falling edge. It limits random addresses to a small window that is preloaded first, so reads never return uninitialised words and address collisions between the ports happen often. Both modes are exercised, and the busy inputs that the current mode ignores are toggled as well.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned NPORTS = 2;

  typedef struct packed {
    logic wr;
    logic rd;
  } port_op_t;
endpackage

// File: rtl/dpr_rst_sync.sv
module dpr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dpr_port_dec.sv
module dpr_port_dec
  import dpr_pkg::*;
(
  input  logic     master_sel,
  input  logic     arb_busy,
  input  logic     ext_busy,
  input  logic     sel_n,
  input  logic     wr_n,
  input  logic     oe_n,
  output port_op_t op,
  output logic     busy_out
);
  logic busy_eff;

  // busy source follows the mode input
  always_comb begin
    busy_eff = master_sel ? arb_busy : ext_busy;
    busy_out = master_sel & arb_busy;
  end

  // output enable plays no part in a write
  always_comb begin
    op.wr = !sel_n && !wr_n && !busy_eff;
    op.rd = !sel_n &&  wr_n && !oe_n && !busy_eff;
  end
endmodule

// File: rtl/dpr_core.sv
module dpr_core
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 9
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  port_op_t [NPORTS-1:0]           op,
  input  logic     [NPORTS-1:0][ADDR_W-1:0] addr,
  input  logic     [NPORTS-1:0][DATA_W-1:0] wdata,
  output logic     [NPORTS-1:0][DATA_W-1:0] rdata,
  output logic     [NPORTS-1:0]           rvalid
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // storage has no reset; port 0 is applied last so it wins a same-address clash
  always_ff @(posedge clk) begin
    for (int p = NPORTS - 1; p >= 0; p--) begin
      if (op[p].wr) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_rd
    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic              rvalid_d, rvalid_q;

    // read-first: the array value seen here is the pre-edge content
    always_comb begin
      rvalid_d = op[p].rd;
      rdata_d  = rdata_q;
      if (op[p].rd) rdata_d = mem[addr[p]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rvalid_q <= 1'b0;
        rdata_q  <= '0;
      end else begin
        rvalid_q <= rvalid_d;
        rdata_q  <= rdata_d;
      end
    end

    assign rdata[p]  = rdata_q;
    assign rvalid[p] = rvalid_q;
  end
endmodule

// File: rtl/dual_port_busy_ram.sv
module dual_port_busy_ram
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_sel,
  input  logic              arb_busy_a,
  input  logic              arb_busy_b,
  input  logic              ext_busy_a,
  input  logic              ext_busy_b,
  output logic              busy_out_a,
  output logic              busy_out_b,
  input  logic              a_sel_n,
  input  logic              a_wr_n,
  input  logic              a_oe_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic              b_sel_n,
  input  logic              b_wr_n,
  input  logic              b_oe_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid
);
  logic rst_n_s;

  logic     [NPORTS-1:0]             arb_busy, ext_busy, sel_n, wr_n, oe_n, busy_out;
  logic     [NPORTS-1:0][ADDR_W-1:0] addr;
  logic     [NPORTS-1:0][DATA_W-1:0] wdata, rdata;
  logic     [NPORTS-1:0]             rvalid;
  port_op_t [NPORTS-1:0]             op;

  dpr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    arb_busy = {arb_busy_b, arb_busy_a};
    ext_busy = {ext_busy_b, ext_busy_a};
    sel_n    = {b_sel_n, a_sel_n};
    wr_n     = {b_wr_n, a_wr_n};
    oe_n     = {b_oe_n, a_oe_n};
    addr     = {b_addr, a_addr};
    wdata    = {b_wdata, a_wdata};
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    dpr_port_dec u_dec (
      .master_sel (master_sel),
      .arb_busy   (arb_busy[p]),
      .ext_busy   (ext_busy[p]),
      .sel_n      (sel_n[p]),
      .wr_n       (wr_n[p]),
      .oe_n       (oe_n[p]),
      .op         (op[p]),
      .busy_out   (busy_out[p])
    );
  end

  dpr_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .op     (op),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

  assign busy_out_a = busy_out[0];
  assign busy_out_b = busy_out[1];
  assign a_rdata    = rdata[0];
  assign b_rdata    = rdata[1];
  assign a_rvalid   = rvalid[0];
  assign b_rvalid   = rvalid[1];
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_sel,
  input logic              arb_busy_a,
  input logic              arb_busy_b,
  input logic              ext_busy_a,
  input logic              ext_busy_b,
  input logic              busy_out_a,
  input logic              busy_out_b,
  input logic              a_sel_n,
  input logic              a_wr_n,
  input logic              a_oe_n,
  input logic [DATA_W-1:0] a_rdata,
  input logic              a_rvalid,
  input logic              b_sel_n,
  input logic              b_wr_n,
  input logic              b_oe_n,
  input logic [DATA_W-1:0] b_rdata,
  input logic              b_rvalid
);
  logic bz_a, bz_b;
  assign bz_a = master_sel ? arb_busy_a : ext_busy_a;
  assign bz_b = master_sel ? arb_busy_b : ext_busy_b;

  assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    a_rvalid |-> $past(!a_sel_n && a_wr_n && !a_oe_n));
  assert_read_valid_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    b_rvalid |-> $past(!b_sel_n && b_wr_n && !b_oe_n));
  assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    a_sel_n |=> !a_rvalid);
  assert_deselect_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    b_sel_n |=> !b_rvalid);
  assert_write_no_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_wr_n || a_oe_n) |=> !a_rvalid);
  assert_write_no_out_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_wr_n || b_oe_n) |=> !b_rvalid);
  assert_busy_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bz_a |=> !a_rvalid);
  assert_busy_read_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bz_b |=> !b_rvalid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rvalid |-> $stable(a_rdata));
  assert_hold_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !b_rvalid |-> $stable(b_rdata));
  assert_slave_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> !busy_out_a && !busy_out_b);
  assert_master_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    master_sel |-> busy_out_a == arb_busy_a && busy_out_b == arb_busy_b);
endmodule

bind dual_port_busy_ram dpr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .master_sel (master_sel),
  .arb_busy_a (arb_busy_a),
  .arb_busy_b (arb_busy_b),
  .ext_busy_a (ext_busy_a),
  .ext_busy_b (ext_busy_b),
  .busy_out_a (busy_out_a),
  .busy_out_b (busy_out_b),
  .a_sel_n    (a_sel_n),
  .a_wr_n     (a_wr_n),
  .a_oe_n     (a_oe_n),
  .a_rdata    (a_rdata),
  .a_rvalid   (a_rvalid),
  .b_sel_n    (b_sel_n),
  .b_wr_n     (b_wr_n),
  .b_oe_n     (b_oe_n),
  .b_rdata    (b_rdata),
  .b_rvalid   (b_rvalid)
);

// File: tb/dual_port_busy_ram_test.sv
module dual_port_busy_ram_test;
  localparam int AW = 12;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic master_sel, arb_busy_a, arb_busy_b, ext_busy_a, ext_busy_b;
  logic busy_out_a, busy_out_b;
  logic a_sel_n, a_wr_n, a_oe_n, b_sel_n, b_wr_n, b_oe_n;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_rvalid, b_rvalid;

  int n_run = 0;
  int n_fail = 0;
  logic [DW-1:0] model [4096];
  logic [DW-1:0] exp_a_data, exp_b_data;
  logic exp_a_valid, exp_b_valid;

  always #2 clk = ~clk;

  dual_port_busy_ram #(.ADDR_W(AW), .DATA_W(DW)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic busy_of(input logic m, input logic arb, input logic ext);
    return m ? arb : ext;
  endfunction

  task automatic idle_all();
    a_sel_n = 1; a_wr_n = 1; a_oe_n = 1; b_sel_n = 1; b_wr_n = 1; b_oe_n = 1;
  endtask

  // called just after inputs change on a falling edge; checks after the next rising edge
  task automatic step(input string tag);
    logic ba, bb, wa, wb, ra, rb;
    ba = busy_of(master_sel, arb_busy_a, ext_busy_a);
    bb = busy_of(master_sel, arb_busy_b, ext_busy_b);
    wa = !a_sel_n && !a_wr_n && !ba;
    wb = !b_sel_n && !b_wr_n && !bb;
    ra = !a_sel_n && a_wr_n && !a_oe_n && !ba;
    rb = !b_sel_n && b_wr_n && !b_oe_n && !bb;
    #1;
    chk({tag, " R6 busy_out_a"}, busy_out_a, master_sel & arb_busy_a);
    chk({tag, " R6 busy_out_b"}, busy_out_b, master_sel & arb_busy_b);
    exp_a_valid = ra;
    exp_b_valid = rb;
    if (ra) exp_a_data = model[a_addr];
    if (rb) exp_b_data = model[b_addr];
    if (wb) model[b_addr] = b_wdata;
    if (wa) model[a_addr] = a_wdata;
    @(negedge clk);
    chk({tag, " a_rvalid"}, a_rvalid, exp_a_valid);
    chk({tag, " b_rvalid"}, b_rvalid, exp_b_valid);
    chk({tag, " a_rdata"}, a_rdata, exp_a_data);
    chk({tag, " b_rdata"}, b_rdata, exp_b_data);
  endtask

  initial begin
    rst_n = 0; master_sel = 1; arb_busy_a = 0; arb_busy_b = 0; ext_busy_a = 0; ext_busy_b = 0;
    idle_all(); a_addr = 0; b_addr = 0; a_wdata = 0; b_wdata = 0;
    exp_a_data = 0; exp_b_data = 0;
    repeat (3) @(negedge clk);
    chk("R2 reset a_rvalid", a_rvalid, 0);
    chk("R2 reset b_rvalid", b_rvalid, 0);
    chk("R2 reset a_rdata", a_rdata, 0);
    chk("R2 reset b_rdata", b_rdata, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // preload window 0..15 from A, top address from B
    for (int i = 0; i < 16; i++) begin
      idle_all(); a_sel_n = 0; a_wr_n = 0; a_oe_n = 0; a_addr = AW'(i); a_wdata = DW'(i * 29 + 3);
      step("R4 preload oe low");
    end
    idle_all(); b_sel_n = 0; b_wr_n = 0; b_addr = 12'hFFF; b_wdata = 9'h1A5;
    step("R1 write top");
    idle_all(); a_sel_n = 0; a_oe_n = 0; a_addr = 12'hFFF;
    step("R1 read top");
    chk("R1 top word", a_rdata, 9'h1A5);

    // R7: busy write dropped
    idle_all(); arb_busy_a = 1; a_sel_n = 0; a_wr_n = 0; a_addr = 3; a_wdata = 9'h0FF;
    step("R7 busy write");
    arb_busy_a = 0; idle_all(); a_sel_n = 0; a_addr = 3; a_oe_n = 0;
    step("R7 read back");
    chk("R7 old kept", a_rdata, 9'(3 * 29 + 3));

    // R5: oe high read gives nothing
    idle_all(); a_sel_n = 0; a_addr = 4; a_oe_n = 1;
    step("R5 oe high");

    // R8: B busy while A writes 5
    idle_all(); arb_busy_b = 1; a_sel_n = 0; a_wr_n = 0; a_addr = 5; a_wdata = 9'h155;
    b_sel_n = 0; b_oe_n = 0; b_addr = 5;
    step("R8 busy read");
    chk("R8 no valid", b_rvalid, 0);
    arb_busy_b = 0; idle_all(); b_sel_n = 0; b_oe_n = 0; b_addr = 5;
    step("R8 after clear");
    chk("R8 new data", b_rdata, 9'h155);

    // R9: same-cycle cross read is read-first
    idle_all(); a_sel_n = 0; a_wr_n = 0; a_addr = 6; a_wdata = 9'h066;
    b_sel_n = 0; b_oe_n = 0; b_addr = 6;
    step("R9 same cycle");
    chk("R9 old word", b_rdata, 9'(6 * 29 + 3));
    idle_all(); b_sel_n = 0; b_oe_n = 0; b_addr = 6;
    step("R9 next cycle");
    chk("R9 new word", b_rdata, 9'h066);

    // R10: both write same address
    idle_all(); a_sel_n = 0; a_wr_n = 0; b_sel_n = 0; b_wr_n = 0;
    a_addr = 7; b_addr = 7; a_wdata = 9'h0AA; b_wdata = 9'h0BB;
    step("R10 clash");
    idle_all(); b_sel_n = 0; b_oe_n = 0; b_addr = 7;
    step("R10 read");
    chk("R10 port A kept", b_rdata, 9'h0AA);

    // R6: slave mode, external busy gates, arbiter input ignored
    master_sel = 0; ext_busy_a = 1; arb_busy_a = 0;
    idle_all(); a_sel_n = 0; a_wr_n = 0; a_addr = 8; a_wdata = 9'h111;
    step("R6 slave busy write");
    ext_busy_a = 0; arb_busy_a = 1; idle_all(); a_sel_n = 0; a_oe_n = 0; a_addr = 8;
    step("R6 slave read");
    chk("R6 slave old kept", a_rdata, 9'(8 * 29 + 3));
    arb_busy_a = 0;

    // random traffic in the preloaded window
    void'($urandom(32'd1357));
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) master_sel = $urandom_range(0, 1);
      arb_busy_a = ($urandom_range(0, 3) == 0); arb_busy_b = ($urandom_range(0, 3) == 0);
      ext_busy_a = ($urandom_range(0, 3) == 0); ext_busy_b = ($urandom_range(0, 3) == 0);
      a_sel_n = ($urandom_range(0, 4) == 0); a_wr_n = $urandom_range(0, 1); a_oe_n = ($urandom_range(0, 4) == 0);
      b_sel_n = ($urandom_range(0, 4) == 0); b_wr_n = $urandom_range(0, 1); b_oe_n = ($urandom_range(0, 4) == 0);
      a_addr = AW'($urandom_range(0, 15)); b_addr = AW'($urandom_range(0, 15));
      a_wdata = DW'($urandom); b_wdata = DW'($urandom);
      step("R3 R4 R8 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule